// File: doc/BRIEF.md
# Bit-Serial Plane-Equation Pixel Array

This block is a SIMD array covering one rectangular screen tile. Every pixel holds a small bit-addressed memory and a single enable flag, and all pixels evaluate the same plane equation A·x + B·y + C at their own tile-relative coordinates in lockstep. The coefficients are set up once per command in a linear expression tree. The tree holds one running value per column (A·x) and one per row (B·y + C). It then shifts those values out least-significant bit first, one bit plane per cycle. Each pixel joins its column bit and its row bit in a serial full adder. The result, also least-significant bit first, feeds the operation that was selected.

To rasterise a triangle, a controller issues these commands in order. It re-arms the enables. It runs three edge tests, which drop every pixel that lies on the negative side of any edge. It runs a depth test against the stored Z field, which narrows the enables further. It then loads Z, R, G and B as plane equations into memory fields. Only pixels that are still enabled are written, so a fragment replaces the stored depth and colour only where it is strictly nearer. A region clear resets the depth field to the largest positive value. A registered read port returns any pixel's field and enable flag.

Top module: `bsp_array`

## Requirements
- R1: After reset every pixel's memory is zero, every enable flag is 1, `cmd_ready` is 1, and `done` and `rd_valid` are 0.
- R2: Opcode 4 (load) writes (A·x + B·y + C) mod 2^16 into field f of every enabled pixel. Here x is the column, y is the row, and field f occupies memory bits f·16 to f·16+15, least-significant bit first.
- R3: Opcode 5 (accumulate) adds (A·x + B·y + C) into field f of every enabled pixel, modulo 2^16.
- R4: Arithmetic overflow in the coefficient tree or in the accumulation wraps modulo 2^16 without any other effect.
- R5: Opcode 2 (edge) clears the enable of each pixel whose 16-bit result has bit 15 set. It leaves the others unchanged and never sets an enable.
- R6: Three edge commands in a row leave enabled exactly the pixels with a non-negative result on all three edges.
- R7: Opcode 0 (arm) sets every enable flag to 1 and completes in a single step. Codes 6 and 7 are single-step commands that have no effect.
- R8: A disabled pixel's memory is not modified by a load or an accumulate.
- R9: Opcode 1 (clear) writes 0x7FFF into field f of every pixel, whatever its enable flag, and then sets every enable to 1.
- R10: Opcode 3 (depth test) clears the enable of each pixel unless its new value, read as signed, is strictly less than the signed value stored in field f. An equal value fails the test.
- R11: A command is accepted when `cmd_valid` is high while `cmd_ready` is high. `cmd_ready` is low in the next cycle. `done` pulses for one cycle, starting 17 cycles after the accept edge for the 16-step commands and 2 cycles after it for single-step commands.
- R12: A read request returns the selected pixel's field and enable flag on `rd_data` and `rd_en`, with `rd_valid` high, in the cycle after `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Array is idle and can take a command |
| cmd_op | input | 3 | Operation code |
| cmd_fld | input | FLD_W | Target memory field index |
| cmd_a | input | FIELD_W | Coefficient applied to the column coordinate |
| cmd_b | input | FIELD_W | Coefficient applied to the row coordinate |
| cmd_c | input | FIELD_W | Constant term |
| done | output | 1 | One-cycle pulse when a command has finished |
| rd_req | input | 1 | Read request |
| rd_x | input | XW | Column of the pixel to read |
| rd_y | input | YW | Row of the pixel to read |
| rd_fld | input | FLD_W | Field to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | FIELD_W | Field contents of the selected pixel |
| rd_en | output | 1 | Enable flag of the selected pixel |

## Verification
The bench builds the array as a 4-column by 3-row tile with 16-bit fields and a 64-bit pixel memory, so there are four fields. At that size every pixel can be read back after each command. The expected results are small enough to work out by hand, yet the tile is wide enough that edges, depth ties and signed wrap-around each split it into several different pixel groups. A wide coefficient such as 0x2000 per column still pushes the fourth column past the sign bit, which brings the signed depth comparison and the wrap behaviour within reach.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  typedef enum logic [2:0] {
    OP_ARM   = 3'd0,
    OP_CLEAR = 3'd1,
    OP_EDGE  = 3'd2,
    OP_ZTEST = 3'd3,
    OP_LOAD  = 3'd4,
    OP_ACCUM = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } bsp_op_e;

  // One-bit full adder: returns {carry, sum}.
  function automatic logic [1:0] fa(input logic a, input logic b, input logic ci);
    return {(a & b) | (a & ci) | (b & ci), a ^ b ^ ci};
  endfunction

  // LSB-first signed less-than update: a differing higher bit decides.
  // For ordinary bits the smaller value has the 0; on the sign bit the
  // smaller value has the 1.
  function automatic logic lt_step(input logic lt, input logic new_bit,
                                   input logic old_bit, input logic sign);
    if (new_bit == old_bit) return lt;
    return sign ? new_bit : old_bit;
  endfunction

  // Operations that need no bit-plane sweep.
  function automatic logic is_single(input bsp_op_e op);
    return (op == OP_ARM) || (op == OP_RSV6) || (op == OP_RSV7);
  endfunction

  // Operations that write the addressed field only where enabled.
  function automatic logic is_masked_write(input bsp_op_e op);
    return (op == OP_LOAD) || (op == OP_ACCUM);
  endfunction

endpackage

// File: rtl/bsp_seq.sv
module bsp_seq
  import bsp_pkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int FLD_W   = 4,
  localparam int SW     = $clog2(FIELD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [FLD_W-1:0] cmd_fld,
  output logic             cmd_ready,
  output logic             accept,
  output logic             active,
  output logic             first,
  output logic             last,
  output logic [SW-1:0]    step,
  output bsp_op_e          op_q,
  output logic [FLD_W-1:0] fld_q,
  output logic             done
);

  localparam logic [SW-1:0] STEP_MAX = SW'(FIELD_W - 1);

  assign cmd_ready = !active;
  assign accept    = cmd_valid && cmd_ready;
  assign first     = active && (step == '0);
  assign last      = active && (is_single(op_q) ? 1'b1 : (step == STEP_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      op_q   <= OP_ARM;
      fld_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        active <= 1'b1;
        step   <= '0;
        op_q   <= bsp_op_e'(cmd_op);
        fld_q  <= cmd_fld;
      end else if (active) begin
        if (last) active <= 1'b0;
        else      step   <= step + 1'b1;
      end
    end
  end

  // R11: completion pulse is the cycle right after the final step
  p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);
  // R11: done is a single-cycle pulse
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: single-step ops finish on their first step
  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_single(op_q)) |=> !active);
  // R11: the step counter advances by one during a sweep
  p_step_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> (active && step == $past(step) + 1'b1));

endmodule

// File: rtl/bsp_ltree.sv
module bsp_ltree #(
  parameter int TILE_W  = 16,
  parameter int TILE_H  = 8,
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [FIELD_W-1:0] coef_a,
  input  logic [FIELD_W-1:0] coef_b,
  input  logic [FIELD_W-1:0] coef_c,
  output logic [TILE_W-1:0]  col_bit,
  output logic [TILE_H-1:0]  row_bit
);

  // Running sums: column i holds A*i, row j holds B*j + C (modulo 2^FIELD_W).
  logic [FIELD_W-1:0] col_sum [TILE_W];
  logic [FIELD_W-1:0] row_sum [TILE_H];
  logic [FIELD_W-1:0] col_sh  [TILE_W];
  logic [FIELD_W-1:0] row_sh  [TILE_H];

  assign col_sum[0] = '0;
  assign row_sum[0] = coef_c;

  for (genvar i = 1; i < TILE_W; i++) begin : g_col_chain
    assign col_sum[i] = col_sum[i-1] + coef_a;
  end
  for (genvar j = 1; j < TILE_H; j++) begin : g_row_chain
    assign row_sum[j] = row_sum[j-1] + coef_b;
  end

  for (genvar i = 0; i < TILE_W; i++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n)     col_sh[i] <= '0;
      else if (load)  col_sh[i] <= col_sum[i];
      else if (shift) col_sh[i] <= {1'b0, col_sh[i][FIELD_W-1:1]};
    end
    assign col_bit[i] = col_sh[i][0];
  end

  for (genvar j = 0; j < TILE_H; j++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)     row_sh[j] <= '0;
      else if (load)  row_sh[j] <= row_sum[j];
      else if (shift) row_sh[j] <= {1'b0, row_sh[j][FIELD_W-1:1]};
    end
    assign row_bit[j] = row_sh[j][0];
  end

  // R2: column 0 contributes nothing to the plane value
  p_col0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (col_bit[0] == 1'b0));

endmodule

// File: rtl/bsp_pixel.sv
module bsp_pixel
  import bsp_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int MEM_BITS = 208,
  parameter int FLD_W    = 4,
  localparam int SW      = $clog2(FIELD_W),
  localparam int AW      = $clog2(MEM_BITS),
  localparam int NUM_FLD = MEM_BITS / FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               first,
  input  logic               last,
  input  bsp_op_e            op,
  input  logic [FLD_W-1:0]   fld,
  input  logic [SW-1:0]      step,
  input  logic               col_bit,
  input  logic               row_bit,
  input  logic [FLD_W-1:0]   rd_fld,
  output logic [FIELD_W-1:0] rd_word,
  output logic               en
);

  localparam logic [FIELD_W-1:0] Z_FAR = {1'b0, {(FIELD_W-1){1'b1}}};

  logic [MEM_BITS-1:0] mem;
  logic                ce, cm, lt;

  logic          fld_ok, rd_ok;
  logic [AW-1:0] addr, fld_base, rd_base;
  logic          mbit, ebit, sbit, lt_n;
  logic [1:0]    e_fa, m_fa;
  logic          wr_en, wr_bit, en_next;

  assign fld_ok   = 32'(fld) < NUM_FLD;
  assign rd_ok    = 32'(rd_fld) < NUM_FLD;
  assign fld_base = AW'(32'(fld) * FIELD_W);
  assign rd_base  = AW'(32'(rd_fld) * FIELD_W);
  assign addr     = fld_base + AW'(step);
  assign mbit     = fld_ok ? mem[addr] : 1'b0;

  // Plane bit from the tree, then the optional add into memory.
  assign e_fa = fa(col_bit, row_bit, first ? 1'b0 : ce);
  assign ebit = e_fa[0];
  assign m_fa = fa(ebit, mbit, first ? 1'b0 : cm);
  assign sbit = m_fa[0];
  assign lt_n = lt_step(first ? 1'b0 : lt, ebit, mbit, last);

  assign wr_en  = active && fld_ok &&
                  ((is_masked_write(op) && en) || (op == OP_CLEAR));
  assign wr_bit = (op == OP_CLEAR) ? !last :
                  (op == OP_ACCUM) ? sbit  : ebit;

  always_comb begin
    en_next = en;
    if (active && last) begin
      case (op)
        OP_ARM, OP_CLEAR: en_next = 1'b1;
        OP_EDGE:          en_next = en & ~ebit;
        OP_ZTEST:         en_next = en & lt_n;
        default:          en_next = en;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
      en  <= 1'b1;
      ce  <= 1'b0;
      cm  <= 1'b0;
      lt  <= 1'b0;
    end else begin
      if (active) begin
        ce <= e_fa[1];
        cm <= m_fa[1];
        lt <= lt_n;
      end
      if (wr_en) mem[addr] <= wr_bit;
      en <= en_next;
    end
  end

  assign rd_word = rd_ok ? mem[rd_base +: FIELD_W] : '0;

  // R8: a masked pixel keeps its memory through load and accumulate
  p_masked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !en && op != OP_CLEAR) |=> $stable(mem));
  // R5: edge and depth tests can only drop an enable
  p_test_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !en && (op == OP_EDGE || op == OP_ZTEST)) |=> !en);
  // R7: arm leaves the pixel enabled
  p_arm_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last && op == OP_ARM) |=> en);
  // R9: clear leaves far depth and an enabled pixel
  p_clear_far_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last && op == OP_CLEAR && fld_ok) |=>
      (en && mem[fld_base +: FIELD_W] == Z_FAR));

endmodule

// File: rtl/bsp_array.sv
module bsp_array
  import bsp_pkg::*;
#(
  parameter int TILE_W   = 16,
  parameter int TILE_H   = 8,
  parameter int FIELD_W  = 16,
  parameter int MEM_BITS = 208,
  localparam int NUM_FLD = MEM_BITS / FIELD_W,
  localparam int FLD_W   = $clog2(NUM_FLD),
  localparam int XW      = $clog2(TILE_W),
  localparam int YW      = $clog2(TILE_H),
  localparam int NPIX    = TILE_W * TILE_H,
  localparam int PW      = $clog2(NPIX),
  localparam int SW      = $clog2(FIELD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [FLD_W-1:0]   cmd_fld,
  input  logic [FIELD_W-1:0] cmd_a,
  input  logic [FIELD_W-1:0] cmd_b,
  input  logic [FIELD_W-1:0] cmd_c,
  output logic               done,
  input  logic               rd_req,
  input  logic [XW-1:0]      rd_x,
  input  logic [YW-1:0]      rd_y,
  input  logic [FLD_W-1:0]   rd_fld,
  output logic               rd_valid,
  output logic [FIELD_W-1:0] rd_data,
  output logic               rd_en
);

  logic             accept, active, first, last;
  logic [SW-1:0]    step;
  bsp_op_e          op_q;
  logic [FLD_W-1:0] fld_q;
  logic [TILE_W-1:0] col_bit;
  logic [TILE_H-1:0] row_bit;

  logic [FIELD_W-1:0] words  [NPIX];
  logic [NPIX-1:0]    en_vec;

  bsp_seq #(.FIELD_W(FIELD_W), .FLD_W(FLD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_fld(cmd_fld), .cmd_ready(cmd_ready), .accept(accept),
    .active(active), .first(first), .last(last), .step(step),
    .op_q(op_q), .fld_q(fld_q), .done(done)
  );

  bsp_ltree #(.TILE_W(TILE_W), .TILE_H(TILE_H), .FIELD_W(FIELD_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(active),
    .coef_a(cmd_a), .coef_b(cmd_b), .coef_c(cmd_c),
    .col_bit(col_bit), .row_bit(row_bit)
  );

  for (genvar y = 0; y < TILE_H; y++) begin : g_row
    for (genvar x = 0; x < TILE_W; x++) begin : g_col
      bsp_pixel #(.FIELD_W(FIELD_W), .MEM_BITS(MEM_BITS), .FLD_W(FLD_W)) u_px (
        .clk(clk), .rst_n(rst_n), .active(active), .first(first),
        .last(last), .op(op_q), .fld(fld_q), .step(step),
        .col_bit(col_bit[x]), .row_bit(row_bit[y]),
        .rd_fld(rd_fld), .rd_word(words[y*TILE_W + x]),
        .en(en_vec[y*TILE_W + x])
      );
    end
  end

  // Registered readout of one pixel.
  logic          rd_in_range;
  logic [PW-1:0] rd_idx;

  assign rd_in_range = (32'(rd_x) < TILE_W) && (32'(rd_y) < TILE_H);
  assign rd_idx      = PW'(32'(rd_y) * TILE_W + 32'(rd_x));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_en    <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_data <= rd_in_range ? words[rd_idx] : '0;
        rd_en   <= rd_in_range ? en_vec[rd_idx] : 1'b0;
      end
    end
  end

  // R12: read data is valid exactly one cycle after the request
  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R11: no new command is taken during a sweep
  p_no_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> !accept);

endmodule

// File: tb/test_bsp_array.sv
module test_bsp_array;

  localparam int TW = 4;
  localparam int TH = 3;
  localparam int NF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_fld = '0;
  logic [15:0] cmd_a = '0, cmd_b = '0, cmd_c = '0;
  logic        done;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_x = '0, rd_y = '0, rd_fld = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        rd_en;

  always #5 clk = ~clk;

  bsp_array #(.TILE_W(TW), .TILE_H(TH), .FIELD_W(16), .MEM_BITS(64)) i_bsp_array (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_fld(cmd_fld), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .cmd_c(cmd_c), .done(done), .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y),
    .rd_fld(rd_fld), .rd_valid(rd_valid), .rd_data(rd_data), .rd_en(rd_en)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] d;
    logic        e;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] m_mem [TW][TH][NF];
  logic        m_en  [TW][TH];

  function automatic logic [15:0] plane(input logic [15:0] a, input logic [15:0] b,
                                        input logic [15:0] c, input int x, input int y);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < x; i++) r = r + a;
    for (int j = 0; j < y; j++) r = r + b;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // Monitor: pops expected readout items as the design returns them.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      exp_t ex;
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected readout", 1, 0);
      end else begin
        ex = exp_q.pop_front();
        check(rd_data === ex.d, {ex.tag, " data"}, int'(rd_data), int'(ex.d));
        check(rd_en === ex.e, {ex.tag, " enable"}, int'(rd_en), int'(ex.e));
      end
    end
  end

  // Driver: read every pixel of a field and queue its expected value.
  task automatic read_all(input int f, input string tag);
    for (int y = 0; y < TH; y++) begin
      for (int x = 0; x < TW; x++) begin
        exp_t ex;
        @(negedge clk);
        rd_req = 1'b1;
        rd_x   = 2'(x);
        rd_y   = 2'(y);
        rd_fld = 2'(f);
        ex.d   = m_mem[x][y][f];
        ex.e   = m_en[x][y];
        ex.tag = $sformatf("%s (R12 readout) px(%0d,%0d) f%0d", tag, x, y, f);
        exp_q.push_back(ex);
      end
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  // Driver: issue one command, check handshake and latency, update the model.
  task automatic run_cmd(input logic [2:0] op, input int f, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] c);
    int n;
    int want;
    @(negedge clk);
    check(cmd_ready === 1'b1, "R11 ready before command", int'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_fld   = 2'(f);
    cmd_a     = a;
    cmd_b     = b;
    cmd_c     = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready === 1'b0, "R11 ready low after accept", int'(cmd_ready), 0);
    n = 1;
    while (done !== 1'b1 && n < 40) begin
      @(negedge clk);
      n++;
    end
    want = (op == 3'd0 || op >= 3'd6) ? 2 : 17;
    check(n == want, "R11 done latency", n, want);
    for (int x = 0; x < TW; x++) begin
      for (int y = 0; y < TH; y++) begin
        logic [15:0] v;
        v = plane(a, b, c, x, y);
        case (op)
          3'd0: m_en[x][y] = 1'b1;
          3'd1: begin m_mem[x][y][f] = 16'h7FFF; m_en[x][y] = 1'b1; end
          3'd2: if (v[15]) m_en[x][y] = 1'b0;
          3'd3: if (!($signed(v) < $signed(m_mem[x][y][f]))) m_en[x][y] = 1'b0;
          3'd4: if (m_en[x][y]) m_mem[x][y][f] = v;
          3'd5: if (m_en[x][y]) m_mem[x][y][f] = m_mem[x][y][f] + v;
          default: ;
        endcase
      end
    end
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int x = 0; x < TW; x++)
      for (int y = 0; y < TH; y++) begin
        m_en[x][y] = 1'b1;
        for (int f = 0; f < NF; f++) m_mem[x][y][f] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cmd_ready === 1'b1, "R1 cmd_ready after reset", int'(cmd_ready), 1);
    check(done === 1'b0, "R1 done after reset", int'(done), 0);
    check(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    read_all(0, "R1 reset field 0");
    read_all(3, "R1 reset field 3");

    // R2: load with mixed signs
    run_cmd(3'd4, 0, 16'd3, 16'd5, 16'hFFF9);
    read_all(0, "R2 load");

    // R3: accumulate into the same field
    run_cmd(3'd5, 0, 16'd1, 16'hFFFE, 16'd100);
    read_all(0, "R3 accumulate");

    // R4: coefficients that overflow the tree and the accumulator
    run_cmd(3'd4, 1, 16'h4000, 16'h3000, 16'h7000);
    run_cmd(3'd5, 1, 16'h6000, 16'h6000, 16'h9000);
    read_all(1, "R4 wrap");

    // R5: edge x - 2 >= 0
    run_cmd(3'd2, 0, 16'd1, 16'd0, 16'hFFFE);
    read_all(0, "R5 edge");

    // R8: masked pixels keep memory on load and accumulate
    run_cmd(3'd4, 2, 16'd0, 16'd0, 16'h0055);
    run_cmd(3'd5, 0, 16'd7, 16'd7, 16'd7);
    read_all(2, "R8 masked load");
    read_all(0, "R8 masked accumulate");

    // R7: arm restores all enables; reserved code has no effect
    run_cmd(3'd0, 0, 16'd0, 16'd0, 16'd0);
    run_cmd(3'd6, 2, 16'd9, 16'd9, 16'd9);
    read_all(2, "R7 arm");

    // R6: three edges x-y>=0, y-1>=0, 2-x>=0
    run_cmd(3'd2, 0, 16'd1, 16'hFFFF, 16'd0);
    run_cmd(3'd2, 0, 16'd0, 16'd1, 16'hFFFF);
    run_cmd(3'd2, 0, 16'hFFFF, 16'd0, 16'd2);
    read_all(0, "R6 triangle");

    // R9: region clear of depth field 3
    run_cmd(3'd1, 3, 16'd0, 16'd0, 16'd0);
    read_all(3, "R9 clear");

    // R10: depth test with a tie and a signed wrap, then conditional write
    run_cmd(3'd3, 3, 16'h2000, 16'd0, 16'h3FFF);
    read_all(3, "R10 depth test vs far");
    run_cmd(3'd4, 3, 16'h2000, 16'd0, 16'h3FFF);
    read_all(3, "R10 depth write");
    run_cmd(3'd0, 0, 16'd0, 16'd0, 16'd0);
    run_cmd(3'd3, 3, 16'd0, 16'd0, 16'h4000);
    read_all(3, "R10 second depth test");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12 readout queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule